// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting a slow reference tick (nominally 1 kHz, presented as a single-cycle enable `tick_i` in the system clock domain). Software must strobe `kick_i` at regular intervals. If it does not, the block raises `wdt_rst_o` as a short system reset pulse. In normal mode, only a late restart is punished. In window mode, each period begins with a closed phase in which a restart counts as a fault, so a restart that comes too early also raises the pulse. After the closed phase comes an open phase in which restarts are accepted.

The configuration holds the enable, the period code, the window code and the window-mode select. It can only be changed by a write that closely follows a key strobe. It can also be frozen until the next power-on reset. Codes 0 to 10 give 8·2^code ticks, which is 8 ms to 8 s at 1 kHz.

The controller has four states:
- OFF: disabled.
- CLOSED: closed window.
- OPEN: open window.
- FIRE: reset pulse.

The transitions are:
- enable: OFF to OPEN or CLOSED.
- close-expire: CLOSED to OPEN.
- early-kick: CLOSED to FIRE.
- restart: OPEN to OPEN or CLOSED.
- timeout: OPEN to FIRE.
- release: FIRE to OPEN, CLOSED or OFF.
- reconfigure: any state except FIRE to OPEN, CLOSED or OFF.

Top module: `wdt_windowed`

## Requirements
- R1: After `rst_ni` low, the watchdog is disabled, unlocked and in normal mode, with period and window codes 0, and `wdt_rst_o` is low.
- R2: In normal mode with period code p (0..10), `wdt_rst_o` rises at the clock edge of the T-th tick after the last counter clear, where T = 8·2^p.
- R3: A `kick_i` in the open phase clears the count and restarts the period. If it falls in the same cycle as the tick that would expire the period, the kick wins and no pulse is raised.
- R4: In window mode with window code w, each period starts with a closed phase of W = 8·2^w ticks. A `kick_i` in that phase, including the cycle of its last tick, raises `wdt_rst_o` at that edge.
- R5: In window mode, the open phase lasts T ticks after the closed phase. With no kick, the pulse rises on tick number W+T.
- R6: `wdt_rst_o` stays high from the firing edge until the edge of the second tick after it, and `kick_i` has no effect meanwhile. Counting then restarts from zero in the start phase: CLOSED in window mode, OPEN otherwise.
- R7: A configuration write (`cfg_we_i`) is accepted only 1 to 4 clock cycles after a `key_i` strobe. Each strobe admits at most one write attempt. Any other write is discarded.
- R8: A write with a period or window code above 10 is discarded as a whole.
- R9: An accepted write clears the count and restarts in the start phase of the new settings, or disables the block when the new enable is 0.
- R10: A high `lock_i` locks the configuration until `rst_ni`. While locked, every write is discarded.
- R11: While disabled, ticks are not counted, `kick_i` is ignored and `wdt_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | Single-cycle reference tick enable |
| kick_i | input | 1 | Software restart strobe |
| key_i | input | 1 | Change-protection key strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Written enable bit |
| cfg_wen_i | input | 1 | Written window-mode select |
| cfg_per_i | input | 4 | Written period code |
| cfg_win_i | input | 4 | Written window code |
| lock_i | input | 1 | Permanent configuration lock request |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
A restart and the tick that ends a phase can fall in the same clock cycle, and the outcome depends on the phase. The bench drives `kick_i` and `tick_i` together on the last tick of the open phase, where the restart must win and no pulse appears. It then drives both together on the last tick of the closed phase, where the restart is early and the pulse must rise at that edge. In both cases the later tick count to the next pulse confirms that the counter was cleared.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_CLOSED = 2'd1,
        ST_OPEN   = 2'd2,
        ST_FIRE   = 2'd3
    } wdt_state_e;

    typedef struct packed {
        logic              en;
        logic              wen;
        logic [CODE_W-1:0] per;
        logic [CODE_W-1:0] win;
    } wdt_cfg_t;

endpackage

// File: rtl/wdt_cfg_guard.sv
module wdt_cfg_guard
    import wdt_win_pkg::*;
#(
    parameter int UNLOCK_CYC = 4,
    parameter int CODE_MAX   = 10
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     key_i,
    input  logic     we_i,
    input  wdt_cfg_t wr_cfg_i,
    input  logic     lock_i,
    output wdt_cfg_t cfg_o,
    output logic     chg_o
);

    localparam int OPEN_W = $clog2(UNLOCK_CYC + 1);

    logic [OPEN_W-1:0] open_q;
    logic              lock_q;
    logic              chg_q;
    wdt_cfg_t          cfg_q;
    logic              codes_ok;
    logic              accept;

    assign codes_ok = (wr_cfg_i.per <= CODE_W'(CODE_MAX)) &&
                      (wr_cfg_i.win <= CODE_W'(CODE_MAX));
    assign accept   = we_i && (open_q != '0) && !lock_q && codes_ok;

    // unlock window: reloaded by the key, closed by any write attempt
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            open_q <= '0;
        end else if (key_i) begin
            open_q <= OPEN_W'(UNLOCK_CYC);
        end else if (we_i) begin
            open_q <= '0;
        end else if (open_q != '0) begin
            open_q <= open_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
        end else if (lock_i) begin
            lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
            chg_q <= 1'b0;
        end else begin
            chg_q <= accept;
            if (accept) begin
                cfg_q <= wr_cfg_i;
            end
        end
    end

    assign cfg_o = cfg_q;
    assign chg_o = chg_q;

    // R7
    chg_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_q |-> $past(we_i));

    // R10
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> lock_q);

    // R10
    locked_no_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> !chg_q);

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_phase_fsm.sv
module wdt_phase_fsm
    import wdt_win_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int HOLD_TICKS = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             cfg_chg_i,
    input  logic             en_i,
    input  logic             wen_i,
    input  logic [CNT_W-1:0] t_lim_i,
    input  logic [CNT_W-1:0] w_lim_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic             rst_o
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    wdt_state_e       state_q;
    wdt_state_e       state_d;
    wdt_state_e       start_st;
    logic             clr_d;
    logic             rst_q;
    logic [CNT_W-1:0] t_last;
    logic [CNT_W-1:0] w_last;

    assign start_st = wen_i ? ST_CLOSED : ST_OPEN;
    assign t_last   = t_lim_i - 1'b1;
    assign w_last   = w_lim_i - 1'b1;

    always_comb begin
        state_d = state_q;
        clr_d   = 1'b0;
        if (cfg_chg_i && (state_q != ST_FIRE)) begin
            state_d = en_i ? start_st : ST_OFF;   // reconfigure
            clr_d   = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_OFF;
                end
                ST_CLOSED: begin
                    if (kick_i) begin
                        state_d = ST_FIRE;          // early-kick
                        clr_d   = 1'b1;
                    end else if (tick_i && (cnt_i == w_last)) begin
                        state_d = ST_OPEN;          // close-expire
                        clr_d   = 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (kick_i) begin
                        state_d = start_st;         // restart
                        clr_d   = 1'b1;
                    end else if (tick_i && (cnt_i == t_last)) begin
                        state_d = ST_FIRE;          // timeout
                        clr_d   = 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (tick_i && (cnt_i == HOLD_LAST)) begin
                        state_d = en_i ? start_st : ST_OFF;  // release
                        clr_d   = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= (state_d == ST_FIRE);
        end
    end

    assign cnt_clr_o = clr_d;
    assign cnt_inc_o = tick_i && (state_q != ST_OFF);
    assign rst_o     = rst_q;

    // R6
    pulse_ends_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_q) |-> $past(tick_i));

    // R4
    early_kick_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CLOSED && kick_i && !cfg_chg_i) |=> rst_q);

    // R3
    open_kick_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OPEN && kick_i && !cfg_chg_i) |=> !rst_q);

    // R2
    open_cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OPEN && !cfg_chg_i) |-> (cnt_i < t_lim_i));

    // R11
    off_stays_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OFF && !cfg_chg_i) |=> (state_q == ST_OFF && !rst_q));

endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
    import wdt_win_pkg::*;
#(
    parameter int BASE_TICKS = 8,
    parameter int CODE_MAX   = 10,
    parameter int UNLOCK_CYC = 4,
    parameter int HOLD_TICKS = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              kick_i,
    input  logic              key_i,
    input  logic              cfg_we_i,
    input  logic              cfg_en_i,
    input  logic              cfg_wen_i,
    input  logic [CODE_W-1:0] cfg_per_i,
    input  logic [CODE_W-1:0] cfg_win_i,
    input  logic              lock_i,
    output logic              wdt_rst_o
);

    localparam int CNT_W = $clog2((BASE_TICKS << CODE_MAX) + 1);

    wdt_cfg_t         wr_cfg;
    wdt_cfg_t         cfg;
    logic             cfg_chg;
    logic [CNT_W-1:0] t_lim;
    logic [CNT_W-1:0] w_lim;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;

    assign wr_cfg.en  = cfg_en_i;
    assign wr_cfg.wen = cfg_wen_i;
    assign wr_cfg.per = cfg_per_i;
    assign wr_cfg.win = cfg_win_i;

    assign t_lim = CNT_W'(BASE_TICKS) << cfg.per;
    assign w_lim = CNT_W'(BASE_TICKS) << cfg.win;

    wdt_cfg_guard #(
        .UNLOCK_CYC (UNLOCK_CYC),
        .CODE_MAX   (CODE_MAX)
    ) u_guard (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .key_i    (key_i),
        .we_i     (cfg_we_i),
        .wr_cfg_i (wr_cfg),
        .lock_i   (lock_i),
        .cfg_o    (cfg),
        .chg_o    (cfg_chg)
    );

    wdt_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt)
    );

    wdt_phase_fsm #(
        .CNT_W      (CNT_W),
        .HOLD_TICKS (HOLD_TICKS)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .kick_i    (kick_i),
        .cfg_chg_i (cfg_chg),
        .en_i      (cfg.en),
        .wen_i     (cfg.wen),
        .t_lim_i   (t_lim),
        .w_lim_i   (w_lim),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .rst_o     (wdt_rst_o)
    );

endmodule

// File: tb/wdt_windowed_bench.sv
`timescale 1ns/1ps
module wdt_windowed_bench;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick_i = 1'b0;
    logic       kick_i = 1'b0;
    logic       key_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_en_i = 1'b0;
    logic       cfg_wen_i = 1'b0;
    logic [3:0] cfg_per_i = 4'd0;
    logic [3:0] cfg_win_i = 4'd0;
    logic       lock_i = 1'b0;
    logic       wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_windowed u_wdt_windowed (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .kick_i    (kick_i),
        .key_i     (key_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_en_i  (cfg_en_i),
        .cfg_wen_i (cfg_wen_i),
        .cfg_per_i (cfg_per_i),
        .cfg_win_i (cfg_win_i),
        .lock_i    (lock_i),
        .wdt_rst_o (wdt_rst_o)
    );

    // {per[3:0], win[3:0], wen, ticks_before_kick[7:0], expect_pulse}
    localparam logic [17:0] VEC [13] = '{
        {4'd0, 4'd0, 1'b0, 8'd7,  1'b0},
        {4'd0, 4'd0, 1'b0, 8'd8,  1'b1},
        {4'd1, 4'd0, 1'b0, 8'd15, 1'b0},
        {4'd1, 4'd0, 1'b0, 8'd16, 1'b1},
        {4'd0, 4'd0, 1'b1, 8'd7,  1'b1},
        {4'd0, 4'd0, 1'b1, 8'd8,  1'b0},
        {4'd0, 4'd0, 1'b1, 8'd15, 1'b0},
        {4'd0, 4'd0, 1'b1, 8'd16, 1'b1},
        {4'd2, 4'd1, 1'b1, 8'd15, 1'b1},
        {4'd2, 4'd1, 1'b1, 8'd16, 1'b0},
        {4'd2, 4'd1, 1'b1, 8'd47, 1'b0},
        {4'd2, 4'd1, 1'b1, 8'd48, 1'b1},
        {4'd0, 4'd0, 1'b1, 8'd0,  1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        tick_i = 0; kick_i = 0; key_i = 0; cfg_we_i = 0; lock_i = 0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); kick_i = 1'b1;
        @(negedge clk); kick_i = 1'b0;
    endtask

    task automatic tick_kick();
        @(negedge clk); tick_i = 1'b1; kick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0; kick_i = 1'b0;
    endtask

    // key strobe, then a write 'dly' cycles later (dly 0: no key at all)
    task automatic write_cfg(input bit en, input int per, input int win, input bit wen, input int dly);
        if (dly > 0) begin
            @(negedge clk); key_i = 1'b1;
            @(negedge clk); key_i = 1'b0;
            repeat (dly - 1) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        cfg_en_i = en; cfg_per_i = 4'(per); cfg_win_i = 4'(win); cfg_wen_i = wen;
        cfg_we_i = 1'b1;
        @(negedge clk); cfg_we_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // issue n ticks, return 1 if the pulse was seen after any of them
    task automatic ticks_seen(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (wdt_rst_o) seen = 1'b1;
        end
    endtask

    initial begin
        bit seen;
        apply_reset();
        // R1: reset state
        check(wdt_rst_o == 1'b0, "R1", wdt_rst_o, 0);
        // R11 / R1: disabled by default, ticks and kicks have no effect
        ticks_seen(40, seen);
        kick();
        check(!seen && !wdt_rst_o, "R11", int'(seen | wdt_rst_o), 0);

        // table of timing vectors
        for (int v = 0; v < 13; v++) begin
            logic [17:0] e;
            int per, win, k, wlen, tlen;
            bit wen, exp, fired;
            string tag;
            e = VEC[v];
            per = int'(e[17:14]); win = int'(e[13:10]); wen = e[9];
            k = int'(e[8:1]); exp = e[0];
            wlen = 8 << win; tlen = 8 << per;
            apply_reset();
            write_cfg(1'b1, per, win, wen, 1);
            fired = 1'b0;
            for (int i = 0; i < k && !fired; i++) begin
                tick();
                if (wdt_rst_o) fired = 1'b1;
            end
            if (!fired) begin
                kick();
                if (wdt_rst_o) fired = 1'b1;
            end
            if (!wen) tag = (k >= tlen) ? "R2" : "R3";
            else if (k < wlen) tag = "R4";
            else tag = "R5";
            check(fired == exp, tag, fired, exp);
        end

        // R7: write 5 cycles after key discarded
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 5);
        ticks_seen(20, seen);
        check(!seen, "R7", seen, 0);
        // R7: write without key discarded
        write_cfg(1'b1, 0, 0, 1'b0, 0);
        ticks_seen(20, seen);
        check(!seen, "R7", seen, 0);
        // R7: write 4 cycles after key accepted
        write_cfg(1'b1, 0, 0, 1'b0, 4);
        ticks_seen(7, seen);
        check(!seen, "R7", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R7", wdt_rst_o, 1);

        // R6: pulse held to second tick, kick ignored, count restarts
        kick();
        check(wdt_rst_o == 1'b1, "R6", wdt_rst_o, 1);
        tick();
        check(wdt_rst_o == 1'b1, "R6", wdt_rst_o, 1);
        tick();
        check(wdt_rst_o == 1'b0, "R6", wdt_rst_o, 0);
        ticks_seen(7, seen);
        check(!seen, "R6", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R6", wdt_rst_o, 1);

        // R8: period code 11 discarded, counter not touched
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        ticks_seen(4, seen);
        write_cfg(1'b1, 11, 0, 1'b0, 1);
        ticks_seen(3, seen);
        check(!seen, "R8", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R8", wdt_rst_o, 1);
        // R8: window code 12 discarded as well (stays normal mode)
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        write_cfg(1'b1, 0, 12, 1'b1, 1);
        kick();
        check(wdt_rst_o == 1'b0, "R8", wdt_rst_o, 0);

        // R9: accepted rewrite clears counter
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        ticks_seen(6, seen);
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        ticks_seen(7, seen);
        check(!seen, "R9", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R9", wdt_rst_o, 1);
        // R9 / R11: disable by write
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        ticks_seen(5, seen);
        write_cfg(1'b0, 0, 0, 1'b0, 1);
        ticks_seen(20, seen);
        check(!seen, "R9", seen, 0);

        // R3: kick clears the count; kick with the expiring tick wins
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        ticks_seen(6, seen);
        kick();
        ticks_seen(7, seen);
        tick_kick();
        check(!seen && !wdt_rst_o, "R3", int'(seen | wdt_rst_o), 0);
        ticks_seen(7, seen);
        check(!seen, "R3", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R3", wdt_rst_o, 1);

        // R4: kick with the last closed-phase tick is early
        apply_reset();
        write_cfg(1'b1, 1, 0, 1'b1, 1);
        ticks_seen(7, seen);
        tick_kick();
        check(wdt_rst_o == 1'b1, "R4", wdt_rst_o, 1);

        // R10: lock freezes configuration
        apply_reset();
        write_cfg(1'b1, 0, 0, 1'b0, 1);
        @(negedge clk); lock_i = 1'b1;
        @(negedge clk); lock_i = 1'b0;
        write_cfg(1'b0, 0, 0, 1'b0, 1);
        ticks_seen(7, seen);
        check(!seen, "R10", seen, 0);
        tick();
        check(wdt_rst_o == 1'b1, "R10", wdt_rst_o, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule